// File: doc/BRIEF.md
# TDM Bit/Word Interleaving Serializer

This block shares one serial line among several multi-bit channel words by giving each transmitted bit its own time slot in a repeating frame. With the default parameters it carries four channels of four bits each, so a frame is sixteen slots long and one bit leaves on each clock. The frame repeats for as long as the block runs.

Two orderings are available. In bit-interleaved order the line first carries bit 0 of every channel in turn, then bit 1 of every channel, and so on up to the top bit. In word-interleaved order one channel keeps the line until its whole word has gone out, least significant bit first, and then the next channel takes over. The ordering and the channel words are both sampled once per frame, so one frame never mixes two orderings or old and new data. A frame-start strobe and the current slot number let a downstream receiver or framer lock onto the sequence.

Top module: `tdm_interleaver`

## Requirements
- R1: While `rst` is high, `slot_o` is 0, `frame_start_o` is 1 and `ser_o` is 0. The frame that starts when reset is released carries all-zero data in bit-interleaved order.
- R2: With mode 0 (bit-interleaved) captured, slot s carries bit (s / NUM_CH) of channel (s mod NUM_CH); for the defaults channel = s[1:0] and bit = s[3:2].
- R3: With mode 1 (word-interleaved) captured, slot s carries bit (s mod CH_W) of channel (s / CH_W); for the defaults channel = s[3:2] and bit = s[1:0].
- R4: In word-interleaved order a channel keeps the line for CH_W consecutive slots before the next channel index takes over.
- R5: After the last slot (NUM_CH*CH_W-1) the slot number returns to 0, and frames repeat with no gap.
- R6: Outside reset the slot number rises by exactly one on every clock within a frame.
- R7: Channel k occupies bits [k*CH_W +: CH_W] of `chan_i`; all channels are sampled together on the clock edge that starts slot 0, and changes to `chan_i` at any other edge have no effect on the serial output of the current frame.
- R8: `frame_start_o` is high for exactly the one clock in which slot 0 is on the line.
- R9: A change of `mode_i` during a frame does not alter that frame's ordering; it is used only from the next slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every slot lasts one cycle |
| rst | input | 1 | Synchronous reset, active high |
| chan_i | input | NUM_CH*CH_W | Packed channel words, channel k at bits [k*CH_W +: CH_W] |
| mode_i | input | 1 | Ordering request: 0 bit-interleaved, 1 word-interleaved |
| ser_o | output | 1 | Serial line, one bit per slot |
| frame_start_o | output | 1 | High during slot 0 |
| slot_o | output | $clog2(NUM_CH*CH_W) | Number of the slot now on the line |

## Verification
The embedded properties assume a synchronous reset that is held for at least one clock edge and parameters that are powers of two; they place no constraint on `chan_i` or `mode_i`, which may change at any edge. The stimulus exploits that freedom: it toggles the ordering request in the middle of frames, rewrites channel words on every clock in some phases, and walks a single one through every bit position under both orderings, so that any bit read from the wrong channel, the wrong position or the wrong frame shows up against the bench model.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

   typedef enum logic {
      TDM_ORDER_BIT  = 1'b0,
      TDM_ORDER_WORD = 1'b1
   } tdm_order_e;

endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
   parameter int SLOTS = 16,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst,
   output logic [SLOT_W-1:0] slot_o,
   output logic              last_o
);

   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

   logic [SLOT_W-1:0] slot_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         slot_q <= '0;
      end else if (slot_q == LAST) begin
         slot_q <= '0;
      end else begin
         slot_q <= slot_q + 1'b1;
      end
   end

   assign slot_o = slot_q;
   assign last_o = (slot_q == LAST);

   // R5: the frame closes back to slot zero
   a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
      (slot_o == LAST) |=> (slot_o == '0));

   // R6: single step within a frame
   a_r6_step: assert property (@(posedge clk) disable iff (rst)
      (slot_o != LAST) |=> (slot_o == $past(slot_o) + 1'b1));

endmodule

// File: rtl/tdm_frame_latch.sv
module tdm_frame_latch #(
   parameter int NUM_CH = 4,
   parameter int CH_W   = 4,
   localparam int TOT_W = NUM_CH * CH_W
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load_i,
   input  logic [TOT_W-1:0]    chan_i,
   input  tdm_pkg::tdm_order_e mode_i,
   output logic [TOT_W-1:0]    words_o,
   output tdm_pkg::tdm_order_e mode_o
);

   tdm_pkg::tdm_order_e mode_q;

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
         logic [CH_W-1:0] word_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               word_q <= '0;
            end else if (load_i) begin
               word_q <= chan_i[k*CH_W +: CH_W];
            end
         end
         assign words_o[k*CH_W +: CH_W] = word_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= tdm_pkg::TDM_ORDER_BIT;
      end else if (load_i) begin
         mode_q <= mode_i;
      end
   end

   assign mode_o = mode_q;

   // R7: no data change except on the frame-boundary edge
   a_r7_hold_words: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(words_o));

   // R9: ordering stays fixed inside a frame
   a_r9_hold_mode: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(mode_o));

endmodule

// File: rtl/tdm_slot_select.sv
module tdm_slot_select #(
   parameter int NUM_CH = 4,
   parameter int CH_W   = 4,
   localparam int TOT_W   = NUM_CH * CH_W,
   localparam int SLOT_W  = $clog2(TOT_W),
   localparam int CH_BITS = $clog2(NUM_CH),
   localparam int BIT_BITS = $clog2(CH_W)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [TOT_W-1:0]    words_i,
   input  tdm_pkg::tdm_order_e mode_i,
   input  logic [SLOT_W-1:0]   slot_i,
   output logic                ser_o
);

   logic [CH_BITS-1:0]  ch_sel;
   logic [BIT_BITS-1:0] bit_sel;
   logic [SLOT_W-1:0]   flat_idx;

   always_comb begin
      if (mode_i == tdm_pkg::TDM_ORDER_WORD) begin
         ch_sel  = slot_i[SLOT_W-1:BIT_BITS];
         bit_sel = slot_i[BIT_BITS-1:0];
      end else begin
         ch_sel  = slot_i[CH_BITS-1:0];
         bit_sel = slot_i[SLOT_W-1:CH_BITS];
      end
   end

   assign flat_idx = {ch_sel, bit_sel};
   assign ser_o    = words_i[flat_idx];

   // R4: a channel holds the line for a full word in word order
   a_r4_word_run: assert property (@(posedge clk) disable iff (rst)
      (mode_i == tdm_pkg::TDM_ORDER_WORD && slot_i[BIT_BITS-1:0] != '1
       && $stable(mode_i)) |=> (ch_sel == $past(ch_sel)) || (mode_i != $past(mode_i)));

   // R2: bit order visits every channel before the next bit position
   a_r2_bit_rotate: assert property (@(posedge clk) disable iff (rst)
      (mode_i == tdm_pkg::TDM_ORDER_BIT && slot_i[CH_BITS-1:0] != '1)
      |=> (mode_i != tdm_pkg::TDM_ORDER_BIT) || (bit_sel == $past(bit_sel)));

endmodule

// File: rtl/tdm_interleaver.sv
module tdm_interleaver #(
   parameter int NUM_CH = 4,
   parameter int CH_W   = 4,
   localparam int TOT_W  = NUM_CH * CH_W,
   localparam int SLOT_W = $clog2(TOT_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [TOT_W-1:0]  chan_i,
   input  logic              mode_i,
   output logic              ser_o,
   output logic              frame_start_o,
   output logic [SLOT_W-1:0] slot_o
);

   generate
      if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
         $error("NUM_CH must be a power of two of at least 2");
      end
      if (CH_W < 2 || (CH_W & (CH_W - 1)) != 0) begin : g_bad_w
         $error("CH_W must be a power of two of at least 2");
      end
   endgenerate

   logic                last_slot;
   logic [TOT_W-1:0]    words_q;
   tdm_pkg::tdm_order_e mode_q;
   tdm_pkg::tdm_order_e mode_req;

   assign mode_req = tdm_pkg::tdm_order_e'(mode_i);

   tdm_slot_counter #(.SLOTS(TOT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .slot_o (slot_o),
      .last_o (last_slot)
   );

   tdm_frame_latch #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_latch (
      .clk     (clk),
      .rst     (rst),
      .load_i  (last_slot),
      .chan_i  (chan_i),
      .mode_i  (mode_req),
      .words_o (words_q),
      .mode_o  (mode_q)
   );

   tdm_slot_select #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sel (
      .clk     (clk),
      .rst     (rst),
      .words_i (words_q),
      .mode_i  (mode_q),
      .slot_i  (slot_o),
      .ser_o   (ser_o)
   );

   assign frame_start_o = (slot_o == '0);

   // R8: the strobe is a single-cycle pulse
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
      frame_start_o |=> !frame_start_o);

   // R8: the strobe returns once the last slot has gone out
   a_r8_after_last: assert property (@(posedge clk) disable iff (rst)
      last_slot |=> frame_start_o);

endmodule

// File: tb/tdm_interleaver_test.sv
`timescale 1ns/1ps
module tdm_interleaver_test;

   localparam int NUM_CH = 4;
   localparam int CH_W   = 4;
   localparam int TOT    = NUM_CH * CH_W;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [TOT-1:0] chan_i = '0;
   logic           mode_i = 1'b0;
   logic           ser_o;
   logic           frame_start_o;
   logic [3:0]     slot_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // behavioural model state
   int m_slot = 0;
   int m_mode = 0;
   int m_words[NUM_CH];
   int prev_ch = -1;

   always #4 clk = ~clk;

   tdm_interleaver #(.NUM_CH(NUM_CH), .CH_W(CH_W)) uut (
      .clk           (clk),
      .rst           (rst),
      .chan_i        (chan_i),
      .mode_i        (mode_i),
      .ser_o         (ser_o),
      .frame_start_o (frame_start_o),
      .slot_o        (slot_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s at %0t: got %0d, expected %0d", req, $time, act, exp);
      end
   endtask

   // advance the model over the posedge just passed, then compare
   task automatic step_and_compare();
      int ch, bt, exp_bit;
      if (m_slot == TOT - 1) begin
         // R7/R9: sample words and ordering only at the frame boundary
         for (int k = 0; k < NUM_CH; k++) m_words[k] = int'(chan_i[k*CH_W +: CH_W]);
         m_mode = int'(mode_i);
         m_slot = 0;
      end else begin
         m_slot++;
      end
      if (m_mode == 1) begin
         ch = m_slot / CH_W;
         bt = m_slot % CH_W;
      end else begin
         ch = m_slot % NUM_CH;
         bt = m_slot / NUM_CH;
      end
      exp_bit = (m_words[ch] >> bt) & 1;
      if (m_mode == 1) check("R3 word-order bit", int'(ser_o), exp_bit);
      else             check("R2 bit-order bit", int'(ser_o), exp_bit);
      if (m_slot == 0) check("R5 wrap to slot 0", int'(slot_o), 0);
      else             check("R6 slot step", int'(slot_o), m_slot);
      check("R8 frame start", int'(frame_start_o), (m_slot == 0) ? 1 : 0);
      // R4: in word order the channel only changes on a word boundary
      if (m_mode == 1 && m_slot % CH_W != 0 && prev_ch >= 0)
         check("R4 channel run", ch, prev_ch);
      prev_ch = ch;
   endtask

   task automatic run(input int n, input bit rnd_data, input bit rnd_mode);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         step_and_compare();
         if (rnd_data) chan_i = TOT'($urandom);
         if (rnd_mode && (i % 7 == 3)) mode_i = ~mode_i;
      end
   endtask

   initial begin
      for (int k = 0; k < NUM_CH; k++) m_words[k] = 0;
      chan_i = 16'hFFFF;
      mode_i = 1'b1;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset slot", int'(slot_o), 0);
      check("R1 reset frame start", int'(frame_start_o), 1);
      check("R1 reset serial", int'(ser_o), 0);
      rst = 1'b0;
      // R1: first frame is all zero in bit order, R7 later edges ignored
      chan_i = 16'hA5C3;
      mode_i = 1'b0;
      run(40, 1'b0, 1'b0);
      // R9: ask for word order mid-frame; takes effect next frame
      mode_i = 1'b1;
      chan_i = 16'h1E7B;
      run(40, 1'b0, 1'b0);
      // walking one through every position in both orders (R2, R3)
      for (int m = 0; m < 2; m++) begin
         for (int b = 0; b < TOT; b++) begin
            mode_i = m[0];
            chan_i = TOT'(1) << b;
            run(TOT, 1'b0, 1'b0);
         end
      end
      // R7/R9: data and mode churn on every clock
      run(800, 1'b1, 1'b1);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule